// File: doc/BRIEF.md
# Video Status Flag Timing Unit

This block holds the two status flags that a raster video unit reports to the CPU: the vertical-blank flag and the sprite-zero hit flag. It runs on the system clock, with the two dot-clock phases arriving as single-cycle enables (`dot_ph0`, `dot_ph1`) and the current scan position arriving as line and dot counts. Each flag is set on one phase of one particular dot. The vertical-blank flag is set on phase 0 of dot 1 on line 241. The sprite-zero flag is set on phase 1 of the dot two positions after the pixel where the overlap was reported.

On the CPU side the block decodes a status read from the read/write line and the low address lines while the CPU clock `m2` is high. The peripheral chip-enable is the inverse of `m2`. During a read the status byte is placed on `rd_data`. When the read strobe ends, the vertical-blank flag is cleared. On the pre-render line, phase 0 of dot 1 clears both flags. All pins are plain control or status pins. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `vstat_flags`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `vblank`, `s0_hit` and `rd_data` are all 0.
- R2: `vblank` becomes 1 on the clock edge of a cycle in which `dot_ph0`=1, `line_cnt`=241 and `dot_cnt`=1. A cycle with `dot_ph1` instead of `dot_ph0`, or with a different line or dot, does not set it.
- R3: After a cycle with `s0_overlap`=1 and position `s0_x`=x, `s0_hit` becomes 1 on the edge of the first cycle that has `dot_ph1`=1 and `dot_cnt`=x+2. It does not become 1 on a `dot_ph0` cycle at that dot.
- R4: `io_ce_n` always equals the inverse of `m2`.
- R5: A status read is active when `m2`=1, `cpu_rw`=1 and `cpu_addr`=3'd2. While a read is active, `rd_data` carries `vblank` in bit 7 and `s0_hit` in bit 6, with bits 5..0 at zero. When no read is active, `rd_data` is 0.
- R6: In the cycle after a status read ends, `vblank` is cleared and `s0_hit` keeps its value. A write (`cpu_rw`=0), or a read from any other address, leaves both flags unchanged.
- R7: A cycle with `dot_ph0`=1, `line_cnt`=261 and `dot_cnt`=1 clears both flags and any pending sprite-zero hit.
- R8: If the vertical-blank set condition occurs in the same cycle as a read-end clear, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_ph0 | input | 1 | Dot-clock phase 0 enable |
| dot_ph1 | input | 1 | Dot-clock phase 1 enable |
| line_cnt | input | 9 | Current scan line |
| dot_cnt | input | 9 | Current dot within the line |
| s0_overlap | input | 1 | Sprite-zero opaque pixel overlap pulse |
| s0_x | input | 8 | X position of the overlap |
| cpu_addr | input | 3 | CPU register address lines |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| m2 | input | 1 | CPU clock phase |
| io_ce_n | output | 1 | Peripheral chip-enable, inverse of m2 |
| rd_data | output | 8 | Status byte during a read, else 0 |
| vblank | output | 1 | Vertical-blank flag |
| s0_hit | output | 1 | Sprite-zero hit flag |

## Verification
The flags are registered, so a set or a clear shows on the ports one clock edge after the cycle that holds its condition. `rd_data` and `io_ce_n` are combinational, so they follow the current inputs in the same cycle. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. At that point it compares both the newly updated flags and the combinational outputs against the inputs it has just applied. The read-clear is checked in the cycle after `m2` falls, because it fires on the end of the strobe and not on its start.

// File: rtl/vstat_pkg.sv
package vstat_pkg;
  localparam int LINE_W      = 9;
  localparam int DOT_W       = 9;
  localparam int X_W         = 8;
  localparam int ADDR_W      = 3;
  localparam int DATA_W      = 8;
  localparam int VBL_LINE    = 241;
  localparam int PRE_LINE    = 261;
  localparam int SET_DOT     = 1;
  localparam int S0_DELAY    = 2;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 3'd2;
  localparam int VBL_BIT     = 7;
  localparam int S0_BIT      = 6;
endpackage

// File: rtl/vstat_cpu_if.sv
module vstat_cpu_if
  import vstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              m2,
  input  logic              vbl,
  input  logic              s0,
  output logic              io_ce_n,
  output logic              rd_end,
  output logic [DATA_W-1:0] rd_data
);
  logic rd_stb, rd_stb_q;

  assign io_ce_n = ~m2;
  assign rd_stb  = ~io_ce_n & cpu_rw & (cpu_addr == STATUS_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) rd_stb_q <= 1'b0;
    else        rd_stb_q <= rd_stb;
  end

  assign rd_end = rd_stb_q & ~rd_stb;

  always_comb begin
    rd_data = '0;
    if (rd_stb) begin
      rd_data[VBL_BIT] = vbl;
      rd_data[S0_BIT]  = s0;
    end
  end
endmodule

// File: rtl/vstat_vbl.sv
module vstat_vbl
  import vstat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph0,
  input  logic [LINE_W-1:0] line,
  input  logic [DOT_W-1:0]  dot,
  input  logic             rd_end,
  input  logic             pre_clr,
  output logic             vbl
);
  logic set_stb;
  assign set_stb = ph0 && (line == LINE_W'(VBL_LINE)) && (dot == DOT_W'(SET_DOT));

  always_ff @(posedge clk) begin
    if (!rst_n)                 vbl <= 1'b0;
    else if (set_stb)           vbl <= 1'b1;
    else if (pre_clr || rd_end) vbl <= 1'b0;
  end
endmodule

// File: rtl/vstat_s0.sv
module vstat_s0
  import vstat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph1,
  input  logic [DOT_W-1:0] dot,
  input  logic             overlap,
  input  logic [X_W-1:0]   x,
  input  logic             pre_clr,
  output logic             s0
);
  logic             pend;
  logic [DOT_W-1:0] tgt;
  logic             fire;

  assign fire = pend && ph1 && (dot == tgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      tgt  <= '0;
      s0   <= 1'b0;
    end else if (pre_clr) begin
      pend <= 1'b0;
      s0   <= 1'b0;
    end else begin
      if (fire) begin
        s0   <= 1'b1;
        pend <= 1'b0;
      end
      if (overlap && !s0 && !pend) begin
        pend <= 1'b1;
        tgt  <= DOT_W'(x) + DOT_W'(S0_DELAY);
      end
    end
  end
endmodule

// File: rtl/vstat_flags.sv
module vstat_flags
  import vstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dot_ph0,
  input  logic              dot_ph1,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [DOT_W-1:0]  dot_cnt,
  input  logic              s0_overlap,
  input  logic [X_W-1:0]    s0_x,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              m2,
  output logic              io_ce_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              vblank,
  output logic              s0_hit
);
  logic pre_clr, rd_end;

  assign pre_clr = dot_ph0 && (line_cnt == LINE_W'(PRE_LINE)) &&
                   (dot_cnt == DOT_W'(SET_DOT));

  vstat_cpu_if u_cpu (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .m2(m2),
    .vbl(vblank), .s0(s0_hit), .io_ce_n(io_ce_n), .rd_end(rd_end),
    .rd_data(rd_data)
  );

  vstat_vbl u_vbl (
    .clk(clk), .rst_n(rst_n), .ph0(dot_ph0), .line(line_cnt), .dot(dot_cnt),
    .rd_end(rd_end), .pre_clr(pre_clr), .vbl(vblank)
  );

  vstat_s0 u_s0 (
    .clk(clk), .rst_n(rst_n), .ph1(dot_ph1), .dot(dot_cnt),
    .overlap(s0_overlap), .x(s0_x), .pre_clr(pre_clr), .s0(s0_hit)
  );
endmodule

// File: rtl/vstat_flags_chk.sv
module vstat_flags_chk
  import vstat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              dot_ph0,
  input logic              dot_ph1,
  input logic [LINE_W-1:0] line_cnt,
  input logic [DOT_W-1:0]  dot_cnt,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rw,
  input logic              m2,
  input logic              io_ce_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              vblank,
  input logic              s0_hit
);
  logic rd_act, pre_pt, vbl_pt;
  assign rd_act = m2 && cpu_rw && (cpu_addr == STATUS_ADDR);
  assign pre_pt = dot_ph0 && (line_cnt == LINE_W'(PRE_LINE)) && (dot_cnt == DOT_W'(SET_DOT));
  assign vbl_pt = dot_ph0 && (line_cnt == LINE_W'(VBL_LINE)) && (dot_cnt == DOT_W'(SET_DOT));

  assert_ce_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_ce_n != m2);

  assert_vbl_set_point_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> $past(vbl_pt));

  assert_s0_set_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s0_hit) |-> $past(dot_ph1));

  assert_idle_bus_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |-> rd_data == '0);

  assert_low_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5:0] == 6'd0);

  assert_s0_only_prerender_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s0_hit) |-> $past(pre_pt));

  assert_prerender_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pre_pt |=> (!vblank && !s0_hit));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_pt |=> vblank);
endmodule

bind vstat_flags vstat_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dot_ph0(dot_ph0), .dot_ph1(dot_ph1),
  .line_cnt(line_cnt), .dot_cnt(dot_cnt), .cpu_addr(cpu_addr),
  .cpu_rw(cpu_rw), .m2(m2), .io_ce_n(io_ce_n), .rd_data(rd_data),
  .vblank(vblank), .s0_hit(s0_hit)
);

// File: tb/tb_vstat_flags.sv
module tb_vstat_flags;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dot_ph0 = 0, dot_ph1 = 0, s0_overlap = 0, cpu_rw = 0, m2 = 0;
  logic [8:0] line_cnt = '0, dot_cnt = '0;
  logic [7:0] s0_x = '0;
  logic [2:0] cpu_addr = '0;
  logic io_ce_n, vblank, s0_hit;
  logic [7:0] rd_data;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vstat_flags dut (.*);

  typedef struct packed {
    logic [8:0] ln; logic [8:0] dt; logic p0; logic p1; logic ov; logic [7:0] x;
    logic m; logic rw; logic [2:0] ad; logic ev; logic es; logic [7:0] er;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{9'd240, 9'd340, 1'b1, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00}, // R2 other line
    '{9'd241, 9'd0,   1'b1, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00}, // R2 dot 0
    '{9'd241, 9'd1,   1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00}, // R2 wrong phase
    '{9'd241, 9'd1,   1'b1, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 8'h00}, // R2 set
    '{9'd241, 9'd2,   1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 1'b1, 3'd2, 1'b1, 1'b0, 8'h80}, // R5 read
    '{9'd241, 9'd2,   1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 8'h00}, // R6 clear
    '{9'd10,  9'd20,  1'b1, 1'b0, 1'b1, 8'd30, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00}, // R3 overlap
    '{9'd10,  9'd32,  1'b1, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00}, // R3 ph0 no set
    '{9'd10,  9'd32,  1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 8'h00}, // R3 set
    '{9'd10,  9'd33,  1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 1'b1, 3'd2, 1'b0, 1'b1, 8'h40}, // R5 read s0
    '{9'd10,  9'd33,  1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 1'b1, 3'd2, 1'b0, 1'b1, 8'h00}, // R6 s0 kept
    '{9'd241, 9'd1,   1'b1, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 8'h00}, // R2 set again
    '{9'd241, 9'd2,   1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 8'h00}, // R6 write
    '{9'd241, 9'd2,   1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 1'b0, 3'd2, 1'b1, 1'b1, 8'h00}, // R6 write no clear
    '{9'd241, 9'd3,   1'b1, 1'b0, 1'b0, 8'd0,  1'b1, 1'b1, 3'd3, 1'b1, 1'b1, 8'h00}, // R6 other addr
    '{9'd241, 9'd3,   1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 1'b1, 3'd3, 1'b1, 1'b1, 8'h00}, // R6 no clear
    '{9'd261, 9'd1,   1'b0, 1'b1, 1'b0, 8'd0,  1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 8'h00}, // R7 wrong phase
    '{9'd261, 9'd1,   1'b1, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00}  // R7 clear
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [8:0] ln, logic [8:0] dt, logic p0, logic p1, logic ov,
                      logic [7:0] x, logic m, logic rw, logic [2:0] ad);
    @(negedge clk);
    line_cnt = ln; dot_cnt = dt; dot_ph0 = p0; dot_ph1 = p1; s0_overlap = ov;
    s0_x = x; m2 = m; cpu_rw = rw; cpu_addr = ad;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(9'd241, 9'd1, 1, 0, 0, 0, 1, 1, 3'd2);
    chk("R1 reset vblank", {7'd0, vblank}, 8'd0);
    chk("R1 reset s0", {7'd0, s0_hit}, 8'd0);
    chk("R1 reset rd", rd_data, 8'h00);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 1, 1, 3'd2);
    chk("R1 after release rd", rd_data, 8'h00);
    chk("R4 ce high m2", {7'd0, io_ce_n}, 8'd0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 ce low m2", {7'd0, io_ce_n}, 8'd1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ln, VEC[i].dt, VEC[i].p0, VEC[i].p1, VEC[i].ov, VEC[i].x,
           VEC[i].m, VEC[i].rw, VEC[i].ad);
      chk($sformatf("R2/R3/R5/R6/R7 vec%0d vblank", i), {7'd0, vblank}, {7'd0, VEC[i].ev});
      chk($sformatf("R3/R6/R7 vec%0d s0_hit", i), {7'd0, s0_hit}, {7'd0, VEC[i].es});
      chk($sformatf("R5 vec%0d rd_data", i), rd_data, VEC[i].er);
    end

    // R8: read ends in the same cycle as the set point
    step(9'd240, 9'd5, 1, 0, 0, 0, 1, 1, 3'd2);
    step(9'd241, 9'd1, 1, 0, 0, 0, 0, 1, 3'd2);
    chk("R8 set beats read clear", {7'd0, vblank}, 8'd1);
    step(9'd241, 9'd2, 0, 1, 0, 0, 1, 1, 3'd2);
    chk("R8 readback after collision", rd_data, 8'h80);

    // R7: pending sprite-zero hit dropped by pre-render clear
    step(9'd261, 9'd0, 1, 0, 1, 8'd0, 0, 0, 0);
    step(9'd261, 9'd1, 1, 0, 0, 0, 0, 0, 0);
    step(9'd261, 9'd2, 0, 1, 0, 0, 0, 0, 0);
    chk("R7 pending dropped", {7'd0, s0_hit}, 8'd0);
    chk("R7 vblank cleared", {7'd0, vblank}, 8'd0);

    // R3: high x position, target dot 257
    step(9'd5, 9'd250, 1, 0, 1, 8'd255, 0, 0, 0);
    step(9'd5, 9'd256, 0, 1, 0, 0, 0, 0, 0);
    chk("R3 early dot no set", {7'd0, s0_hit}, 8'd0);
    step(9'd5, 9'd257, 0, 1, 0, 0, 0, 0, 0);
    chk("R3 x=255 set at 257", {7'd0, s0_hit}, 8'd1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule